// File: doc/BRIEF.md
# Posted-CAS Data Bus Scheduler

This block lives in the controller half of a double-data-rate memory path. Column commands arrive as a stream. Each one is a READ or a WRITE and carries a small burst tag. From the two programmable latencies, the block works out which future clock cycles the shared data bus will occupy. It then drives three windows at the right moment: a capture window for read data, a drive window for write data, and an output enable for the write strobe. The burst tag is shown alongside whichever data window is active.

Two latencies are programmable: an additive latency (AL, 0 to 4) and a CAS latency (CL, 3 to 5). Read data starts AL+CL clocks after the command, and write data one clock earlier than that. Each burst comes from a four-deep prefetch and is double-pumped, so it fills exactly two clocks. A command whose two data cycles would land on a cycle that is already booked is refused. The refusal is made in the cycle the command is presented, so the issuing logic can reorder and try again later.

The command port follows valid/ready rules. `cmd_ready` depends only on the presented command type (`cmd_is_wr`) and the current bookings, never on `cmd_valid`. A transfer happens when both are high at a rising edge. When `cmd_ready` is low because of a clash, `cmd_collide` reports the clash for a valid command. The sender may hold the command, change it or drop it. While reset is high, `cmd_ready` stays low.

Top module: `pcas_sched`

## Requirements
- R1: A READ accepted in cycle c raises `rd_capture` in exactly cycles c+AL+CL and c+AL+CL+1, and shows its tag on `data_tag` in those cycles. `data_tag` is 0 whenever neither data window is high.
- R2: A WRITE accepted in cycle c raises `wr_drive` in exactly cycles c+AL+CL-1 and c+AL+CL, with its tag on `data_tag`.
- R3: For a WRITE, `dqs_oe` rises one cycle before the first `wr_drive` cycle and stays high until the end of the second `wr_drive` cycle. An isolated write gives three `dqs_oe` cycles.
- R4: Commands of one type issued every two cycles give data windows that follow one another with no idle cycle. This holds for both odd and even CL.
- R5: When any data cycle of a presented command is already booked, `cmd_collide` equals `cmd_valid` and `cmd_ready` is low in that same cycle. The command leaves no window behind.
- R6: `cmd_ready` is low during reset, and otherwise it is low exactly when the presented type would clash. With `cmd_valid` low, `cmd_collide` is 0.
- R7: A latency write (`cfg_we`) takes effect at the next edge only if nothing is booked and AL ≤ 4 and 3 ≤ CL ≤ 5. Otherwise it is ignored. A command accepted in the same cycle uses the old values.
- R8: A synchronous active-high reset drops every booking, holds all three window outputs low from the next cycle, and returns the latencies to AL=0, CL=3.
- R9: `rd_capture` and `wr_drive` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Latency write strobe |
| cfg_add_lat | input | 3 | Additive latency to load |
| cfg_cas_lat | input | 3 | CAS latency to load |
| cmd_valid | input | 1 | Column command present |
| cmd_ready | output | 1 | Command would be accepted |
| cmd_is_wr | input | 1 | 1 = WRITE, 0 = READ |
| cmd_tag | input | 4 | Burst tag |
| cmd_collide | output | 1 | Presented command refused for data-bus overlap |
| rd_capture | output | 1 | Read data capture window |
| wr_drive | output | 1 | Write data drive window |
| dqs_oe | output | 1 | Write strobe output enable, including preamble |
| data_tag | output | 4 | Tag of the burst in the active data window |

## Verification
A corrupted booking shows at the ports in one of two ways. Either a window shows up in a cycle that is one off from AL+CL, or a legal command meets a spurious `cmd_collide` as soon as it aims at the stale slot. The bench therefore compares all four window outputs against a timeline it builds itself, every cycle, so an error is seen in the cycle it surfaces. A latency register that loaded when it should not have would move the very next window. That is why each ignored write is followed by a read whose capture cycle is checked exactly.

// File: rtl/pcas_pkg.sv
`timescale 1ns/1ps
package pcas_pkg;
  typedef enum logic {KIND_RD = 1'b0, KIND_WR = 1'b1} kind_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pcas_lat_cfg.sv
`timescale 1ns/1ps
module pcas_lat_cfg #(
  parameter int LAT_W  = 3,
  parameter int IDX_W  = 4,
  parameter int AL_MAX = 4,
  parameter int CL_MIN = 3,
  parameter int CL_MAX = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [LAT_W-1:0] al_in,
  input  logic [LAT_W-1:0] cl_in,
  input  logic             busy_any,
  output logic [IDX_W-1:0] rd_lat,
  output logic [IDX_W-1:0] wr_lat
);
  logic [LAT_W-1:0] al_q, cl_q;
  logic             in_range, take;

  assign in_range = (al_in <= LAT_W'(AL_MAX)) &&
                    (cl_in >= LAT_W'(CL_MIN)) && (cl_in <= LAT_W'(CL_MAX));
  assign take = we && !busy_any && in_range;

  always_ff @(posedge clk) begin
    if (rst) begin
      al_q <= '0;
      cl_q <= LAT_W'(CL_MIN);
    end else if (take) begin
      al_q <= al_in;
      cl_q <= cl_in;
    end
  end

  assign rd_lat = IDX_W'(al_q) + IDX_W'(cl_q);
  assign wr_lat = rd_lat - 1'b1;
endmodule

// File: rtl/pcas_clash.sv
`timescale 1ns/1ps
module pcas_clash #(
  parameter int DEPTH = 11,
  parameter int IDX_W = 4
) (
  input  logic [DEPTH-1:0] booked,
  input  logic [IDX_W-1:0] first,
  output logic             clash
);
  logic [DEPTH-1:0] hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_probe
    assign hit[i] = booked[i] &&
                    ((IDX_W'(i) == first) || (IDX_W'(i) == first + 1'b1));
  end

  assign clash = |hit;
endmodule

// File: rtl/pcas_timeline.sv
`timescale 1ns/1ps
module pcas_timeline #(
  parameter int DEPTH = 11,
  parameter int TAG_W = 4,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_en,
  input  logic             ins_wr,
  input  logic [TAG_W-1:0] ins_tag,
  input  logic [IDX_W-1:0] ins_first,
  output logic [DEPTH-1:0] booked,
  output logic             head_busy,
  output logic             head_wr,
  output logic             head_strb,
  output logic [TAG_W-1:0] head_tag,
  output logic             any_pending
);
  logic [DEPTH-1:0] busy_q, wr_q, strb_q;
  logic [DEPTH-1:0] busy_d, wr_d, strb_d;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [TAG_W-1:0] tag_d [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic             nb, nw, ns;
    logic [TAG_W-1:0] nt;
    logic             hit_data, hit_pre;

    if (i < DEPTH - 1) begin : g_shift
      assign nb = busy_q[i+1];
      assign nw = wr_q[i+1];
      assign ns = strb_q[i+1];
      assign nt = tag_q[i+1];
    end else begin : g_tail
      assign nb = 1'b0;
      assign nw = 1'b0;
      assign ns = 1'b0;
      assign nt = '0;
    end

    // slot i after this edge stands for index i+1 of the current cycle
    assign hit_data = ins_en && ((IDX_W'(i + 1) == ins_first) ||
                                 (IDX_W'(i + 1) == ins_first + 1'b1));
    assign hit_pre  = ins_en && ins_wr && (IDX_W'(i + 2) == ins_first);

    assign busy_d[i] = nb | hit_data;
    assign wr_d[i]   = hit_data ? ins_wr : nw;
    assign strb_d[i] = ns | hit_pre | (hit_data & ins_wr);
    assign tag_d[i]  = hit_data ? ins_tag : nt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
      wr_q   <= '0;
      strb_q <= '0;
      tag_q  <= '{default: '0};
    end else begin
      busy_q <= busy_d;
      wr_q   <= wr_d;
      strb_q <= strb_d;
      tag_q  <= tag_d;
    end
  end

  assign booked      = busy_q;
  assign head_busy   = busy_q[0];
  assign head_wr     = wr_q[0];
  assign head_strb   = strb_q[0];
  assign head_tag    = tag_q[0];
  assign any_pending = (|busy_q) | (|strb_q);
endmodule

// File: rtl/pcas_sched.sv
`timescale 1ns/1ps
module pcas_sched #(
  parameter int TAG_W  = 4,
  parameter int AL_MAX = 4,
  parameter int CL_MIN = 3,
  parameter int CL_MAX = 5,
  localparam int LAT_W = $clog2(pcas_pkg::max2(AL_MAX, CL_MAX) + 1),
  localparam int RL_MAX = AL_MAX + CL_MAX,
  localparam int DEPTH = RL_MAX + 2,
  localparam int IDX_W = $clog2(DEPTH + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [LAT_W-1:0] cfg_add_lat,
  input  logic [LAT_W-1:0] cfg_cas_lat,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_is_wr,
  input  logic [TAG_W-1:0] cmd_tag,
  output logic             cmd_collide,
  output logic             rd_capture,
  output logic             wr_drive,
  output logic             dqs_oe,
  output logic [TAG_W-1:0] data_tag
);
  import pcas_pkg::*;

  logic [IDX_W-1:0] rd_lat, wr_lat, first;
  logic [DEPTH-1:0] booked;
  logic             clash, accept, pending;
  logic             head_busy, head_wr, head_strb;
  logic [TAG_W-1:0] head_tag;
  kind_e            kind;

  pcas_lat_cfg #(
    .LAT_W(LAT_W), .IDX_W(IDX_W),
    .AL_MAX(AL_MAX), .CL_MIN(CL_MIN), .CL_MAX(CL_MAX)
  ) u_lat (
    .clk(clk), .rst(rst), .we(cfg_we),
    .al_in(cfg_add_lat), .cl_in(cfg_cas_lat),
    .busy_any(pending), .rd_lat(rd_lat), .wr_lat(wr_lat)
  );

  assign kind  = kind_e'(cmd_is_wr);
  assign first = (kind == KIND_WR) ? wr_lat : rd_lat;

  pcas_clash #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_clash (
    .booked(booked), .first(first), .clash(clash)
  );

  assign cmd_ready   = !rst && !clash;
  assign cmd_collide = !rst && cmd_valid && clash;
  assign accept      = cmd_valid && cmd_ready;

  pcas_timeline #(.DEPTH(DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_line (
    .clk(clk), .rst(rst),
    .ins_en(accept), .ins_wr(kind == KIND_WR), .ins_tag(cmd_tag),
    .ins_first(first), .booked(booked),
    .head_busy(head_busy), .head_wr(head_wr), .head_strb(head_strb),
    .head_tag(head_tag), .any_pending(pending)
  );

  assign rd_capture = head_busy && !head_wr;
  assign wr_drive   = head_busy && head_wr;
  assign dqs_oe     = head_strb;
  assign data_tag   = head_busy ? head_tag : '0;
endmodule

// File: rtl/pcas_sched_chk.sv
`timescale 1ns/1ps
module pcas_sched_chk #(
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             cmd_collide,
  input logic             rd_capture,
  input logic             wr_drive,
  input logic             dqs_oe,
  input logic [TAG_W-1:0] data_tag
);
  a_r5_refused_not_ready: assert property (@(posedge clk) disable iff (rst)
    cmd_collide |-> !cmd_ready);

  a_r6_collide_needs_valid: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |-> !cmd_collide);

  a_r6_ready_low_in_reset: assert property (@(posedge clk)
    rst |-> !cmd_ready);

  a_r9_bus_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rd_capture && wr_drive));

  a_r3_strobe_covers_data: assert property (@(posedge clk) disable iff (rst)
    wr_drive |-> dqs_oe);

  a_r3_preamble: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_drive) |-> $past(dqs_oe));

  a_r1_two_cycle_read: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_capture) |=> rd_capture);

  a_r2_two_cycle_write: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_drive) |=> wr_drive);

  a_r1_tag_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !(rd_capture || wr_drive) |-> (data_tag == '0));

  a_r8_reset_quiet: assert property (@(posedge clk)
    rst |=> (!rd_capture && !wr_drive && !dqs_oe));
endmodule

bind pcas_sched pcas_sched_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_collide(cmd_collide), .rd_capture(rd_capture), .wr_drive(wr_drive),
  .dqs_oe(dqs_oe), .data_tag(data_tag)
);

// File: tb/test_pcas_sched.sv
`timescale 1ns/1ps
module test_pcas_sched;
  localparam int NCYC = 4096;
  // entry: {is_wr, tag[3:0], expect_collide, cycles_to_next[3:0]}
  localparam logic [9:0] TBL [10] = '{
    10'b0_0001_0_0010, 10'b0_0010_0_0001, 10'b0_0011_1_0001,
    10'b1_0100_1_0001, 10'b1_0101_0_0010, 10'b1_0110_0_0010,
    10'b0_0111_0_0001, 10'b1_1000_1_1100, 10'b1_1001_0_1000,
    10'b0_1010_0_1000
  };

  logic       clk = 1'b0, rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_add_lat = '0, cfg_cas_lat = '0;
  logic       cmd_valid = 1'b0, cmd_is_wr = 1'b0;
  logic [3:0] cmd_tag = '0;
  logic       cmd_ready, cmd_collide, rd_capture, wr_drive, dqs_oe;
  logic [3:0] data_tag;

  int  cyc = 0, n_chk = 0, n_fail = 0;
  bit  chk_on = 1'b0;
  int  m_al = 0, m_cl = 3;
  bit  exp_rd [NCYC];
  bit  exp_wr [NCYC];
  bit  exp_oe [NCYC];
  logic [3:0] exp_tg [NCYC];

  pcas_sched i_pcas_sched (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_add_lat(cfg_add_lat),
    .cfg_cas_lat(cfg_cas_lat), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_is_wr(cmd_is_wr), .cmd_tag(cmd_tag), .cmd_collide(cmd_collide),
    .rd_capture(rd_capture), .wr_drive(wr_drive), .dqs_oe(dqs_oe),
    .data_tag(data_tag)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s cycle=%0d actual=%0d expected=%0d", rq, what, cyc, act, exp);
    end
  endtask

  // per-cycle scoreboard of the data windows
  always @(negedge clk) if (chk_on) begin
    chk(rd_capture == exp_rd[cyc], "R1", "rd_capture", int'(rd_capture), int'(exp_rd[cyc]));
    chk(wr_drive == exp_wr[cyc], "R2", "wr_drive", int'(wr_drive), int'(exp_wr[cyc]));
    chk(dqs_oe == exp_oe[cyc], "R3", "dqs_oe", int'(dqs_oe), int'(exp_oe[cyc]));
    chk(data_tag == exp_tg[cyc], "R1", "data_tag", int'(data_tag), int'(exp_tg[cyc]));
  end

  function automatic bit m_clash(bit w);
    int f = cyc + m_al + m_cl - (w ? 1 : 0);
    return exp_rd[f] | exp_wr[f] | exp_rd[f+1] | exp_wr[f+1];
  endfunction

  function automatic bit m_pending();
    for (int k = cyc; k < cyc + 14; k++)
      if (exp_rd[k] || exp_wr[k] || exp_oe[k]) return 1'b1;
    return 1'b0;
  endfunction

  // ecol < 0: expected collision from the bench timeline
  task automatic drive(bit v, bit w, logic [3:0] t, bit cwe, int al, int cl, int ecol);
    bit mc, pend, ex;
    int f;
    @(negedge clk);
    cmd_valid = v; cmd_is_wr = w; cmd_tag = t;
    cfg_we = cwe; cfg_add_lat = 3'(al); cfg_cas_lat = 3'(cl);
    #1;
    mc   = m_clash(w);
    ex   = (ecol < 0) ? mc : bit'(ecol);
    pend = m_pending();
    chk(cmd_collide == (v && ex), "R5", "cmd_collide", int'(cmd_collide), int'(v && ex));
    chk(cmd_ready == !ex, "R6", "cmd_ready", int'(cmd_ready), int'(!ex));
    if (v && !mc) begin
      f = cyc + m_al + m_cl - (w ? 1 : 0);
      for (int k = 0; k < 2; k++) begin
        if (w) exp_wr[f+k] = 1'b1; else exp_rd[f+k] = 1'b1;
        exp_tg[f+k] = t;
      end
      if (w) for (int k = -1; k < 2; k++) exp_oe[f+k] = 1'b1;
    end
    if (cwe && !pend && al <= 4 && cl >= 3 && cl <= 5) begin
      m_al = al; m_cl = cl;
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) drive(0, 0, 4'h0, 0, 0, 0, -1);
  endtask

  task automatic wait_cycle(int c);
    while (cyc < c) idle(1);
  endtask

  // three same-type commands two cycles apart, windows must touch (R4)
  task automatic seam(int al, int cl, bit w, logic [3:0] t0);
    int c0, lat;
    idle(14);
    drive(0, 0, 4'h0, 1, al, cl, -1);
    lat = w ? al + cl - 1 : al + cl;
    drive(1, w, t0, 0, 0, 0, 0);
    c0 = cyc;
    idle(1);
    drive(1, w, 4'(t0 + 1), 0, 0, 0, 0);
    idle(1);
    drive(1, w, 4'(t0 + 2), 0, 0, 0, 0);
    for (int j = 0; j < 6; j++) begin
      wait_cycle(c0 + lat + j);
      chk((w ? wr_drive : rd_capture) == 1'b1, "R4", "seamless window",
          int'(w ? wr_drive : rd_capture), 1);
    end
    if (w) begin
      wait_cycle(c0 + lat + 6);
      chk(dqs_oe == 1'b0, "R3", "strobe off after last burst", int'(dqs_oe), 0);
    end
  endtask

  task automatic do_reset(int n);
    @(negedge clk);
    rst = 1'b1; cmd_valid = 1'b0; cfg_we = 1'b0;
    for (int k = cyc + 1; k < NCYC; k++) begin
      exp_rd[k] = 0; exp_wr[k] = 0; exp_oe[k] = 0; exp_tg[k] = '0;
    end
    m_al = 0; m_cl = 3;
    #1;
    chk(cmd_ready == 1'b0, "R6", "ready during reset", int'(cmd_ready), 0);
    repeat (n) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    int c0;
    for (int k = 0; k < NCYC; k++) begin
      exp_rd[k] = 0; exp_wr[k] = 0; exp_oe[k] = 0; exp_tg[k] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R8 reset state
    chk(!rd_capture && !wr_drive && !dqs_oe && data_tag == 0, "R8", "outputs after reset",
        int'({rd_capture, wr_drive, dqs_oe}), 0);
    chk(cmd_ready == 1'b1, "R6", "ready after reset", int'(cmd_ready), 1);
    chk_on = 1'b1;

    // table walk at AL=0 CL=3: R1 R2 R3 R4 R5 R9
    for (int i = 0; i < 10; i++) begin
      drive(1, TBL[i][9], TBL[i][8:5], 0, 0, 0, int'(TBL[i][4]));
      idle(int'(TBL[i][3:0]) - 1);
    end

    // R6: invalid command that would clash still lowers ready, no collide
    idle(14);
    drive(1, 0, 4'h3, 0, 0, 0, 0);
    drive(0, 1, 4'h0, 0, 0, 0, 1);
    idle(6);

    // R7: latency write while busy is ignored
    drive(1, 0, 4'h4, 0, 0, 0, 0);
    drive(0, 0, 4'h0, 1, 2, 4, -1);
    idle(14);
    drive(1, 0, 4'h5, 0, 0, 0, 0);
    c0 = cyc;
    wait_cycle(c0 + 3);
    chk(rd_capture == 1'b1, "R7", "latency kept after busy write", int'(rd_capture), 1);

    // R7: out-of-range values ignored
    idle(14);
    drive(0, 0, 4'h0, 1, 5, 3, -1);
    drive(0, 0, 4'h0, 1, 0, 2, -1);
    drive(0, 0, 4'h0, 1, 1, 6, -1);
    drive(1, 0, 4'h6, 0, 0, 0, 0);
    c0 = cyc;
    wait_cycle(c0 + 3);
    chk(rd_capture == 1'b1, "R7", "latency kept after range error", int'(rd_capture), 1);

    // R4 odd and even CL, reads and writes, up to the deepest latency
    seam(0, 3, 0, 4'h1);
    seam(2, 4, 0, 4'h4);
    seam(1, 5, 1, 4'h7);
    seam(4, 5, 0, 4'hA);
    seam(4, 5, 1, 4'hC);

    // read then write three cycles later: back-to-back on the bus (R2, R9)
    idle(14);
    drive(0, 0, 4'h0, 1, 2, 4, -1);
    drive(1, 0, 4'h2, 0, 0, 0, 0);
    idle(2);
    drive(1, 1, 4'h3, 0, 0, 0, 0);
    idle(12);

    // R8: reset with bookings pending, latencies return to AL=0 CL=3
    drive(1, 0, 4'h9, 0, 0, 0, 0);
    do_reset(2);
    idle(12);
    drive(1, 0, 4'hB, 0, 0, 0, 0);
    c0 = cyc;
    wait_cycle(c0 + 3);
    chk(rd_capture == 1'b1 && data_tag == 4'hB, "R8", "latency back to reset value",
        int'(data_tag), 11);
    idle(6);

    chk_on = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired at cycle %0d actual=1 expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule